// File: doc/BRIEF.md
# DDR Command Address Tracker

This block sits beside a DDR SDRAM command bus and watches it on the command clock, which runs at half the data rate. It rebuilds the full address of every read and write access from the two-phase command protocol. An ACTIVE command opens a row in one bank. A later READ or WRITE to that bank supplies the column. The block joins the two pieces and emits one trace record for the access.

Each bank has its own four-state tracker, so accesses to different banks may interleave freely. Only ACTIVE, READ and WRITE change anything. Every other command, and every cycle with chip select high, passes without effect.

Each record carries four fields:
- a timestamp taken from a free-running counter;
- a write flag;
- the address `{bank, row, column}`;
- a flag that is set when the address falls inside a reserved control window. Software uses that window to place marker accesses in the trace.

A column command sent to a bank that has no open row is counted as an error and produces no record.

Top module: `ddrtrk_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rec_valid` is 0 and `err_cnt` is 0.
- R2: A command is decoded only while `cs_n` is 0, using active-low pins (ras_n, cas_n, we_n):
  - ACTIVE is (0,1,1).
  - READ is (1,0,1).
  - WRITE is (1,0,0).
  Any other combination, and any cycle with `cs_n` high, has no effect on bank state, records or errors.
- R3: A READ to a bank holding an open row makes `rec_valid` high for one cycle, two rising edges after the edge that samples the command. In that record `rec_write` is 0 and `rec_addr` is `{ba, row, addr[COL_W-1:0]}`, where row is the one latched by that bank's last ACTIVE.
- R4: A WRITE to a bank with an open row produces the same kind of record with `rec_write` equal to 1.
- R5: Each bank keeps its own open row. Commands to different banks may interleave cycle by cycle without disturbing one another.
- R6: Further column commands to a bank that is already in a column state each produce one more record, using the same row.
- R7: A new ACTIVE to a bank with an open row replaces its latched row. Later records for that bank use the new row.
- R8: A READ or WRITE to a bank that has seen no ACTIVE since reset produces no record. It increments `err_cnt` by one; the counter saturates at all ones.
- R9: The timestamp counter is 0 in reset and counts every clock edge after it. `rec_ts` equals the number of edges since reset, up to and including the edge that sampled the column command.
- R10: `rec_ctrl` is 1 exactly when `(rec_addr & CTRL_MASK) == CTRL_BASE`. By default this selects the highest bank together with the all-ones row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ROW_W | Address bus: the row on ACTIVE, the column in the low COL_W bits on READ/WRITE |
| rec_valid | output | 1 | One-cycle strobe marking a new record |
| rec_ts | output | TS_W | Timestamp of the record |
| rec_write | output | 1 | 1 for a write access, 0 for a read |
| rec_addr | output | BANK_W+ROW_W+COL_W | Rebuilt address {bank, row, column} |
| rec_ctrl | output | 1 | Address lies inside the control window |
| err_cnt | output | ERR_W | Saturating count of column commands sent to idle banks |

## Verification
A bank tracker holding the wrong state or row is visible at the ports on the next column command to that bank. Two rising edges later, the record shows a wrong row field, a missing record, or an unexpected `err_cnt` step. For that reason the bench probes every bank state with a follow-up READ: after interleaving, after re-activation, and after every ignored command. A fault in the timestamp or in the window compare appears in the very first record produced after the fault.

// File: rtl/ddrtrk_pkg.sv
package ddrtrk_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE     = 2'd0,
    BK_ROW_OPEN = 2'd1,
    BK_RD_SEEN  = 2'd2,
    BK_WR_SEEN  = 2'd3
  } bank_st_e;

  // Pins are active low; anything but the three tracked patterns is NONE.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/ddrtrk_cmd_decode.sv
module ddrtrk_cmd_decode
  import ddrtrk_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic              cap_en;

  always_comb begin
    cmd_d  = decode_pins(cs_n, ras_n, cas_n, we_n);
    cap_en = (cmd_d != CMD_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NONE;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  // Bank and address are only loaded when a tracked command is present.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q   <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      ba_q   <= ba;
      addr_q <= addr;
    end
  end

  assign cmd_o  = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/ddrtrk_bank_fsm.sv
module ddrtrk_bank_fsm
  import ddrtrk_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] row_in,
  output bank_st_e         state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             emit_o,
  output logic             err_o
);

  bank_st_e         st_d, st_q;
  logic [ROW_W-1:0] row_q;
  logic             row_en;
  logic             col_cmd;

  always_comb begin
    st_d    = st_q;
    row_en  = 1'b0;
    col_cmd = sel && is_column(cmd);
    if (sel) begin
      unique case (cmd)
        CMD_ACT: begin
          st_d   = BK_ROW_OPEN;
          row_en = 1'b1;
        end
        CMD_RD:  if (st_q != BK_IDLE) st_d = BK_RD_SEEN;
        CMD_WR:  if (st_q != BK_IDLE) st_d = BK_WR_SEEN;
        default: st_d = st_q;
      endcase
    end
    emit_o = col_cmd && (st_q != BK_IDLE);
    err_o  = col_cmd && (st_q == BK_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BK_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_in;
    end
  end

  assign state_o = st_q;
  assign row_o   = row_q;

endmodule

// File: rtl/ddrtrk_record.sv
module ddrtrk_record
  import ddrtrk_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int TS_W   = 16,
  parameter int ERR_W  = 8,
  parameter int NB     = 4,
  parameter int AW     = BANK_W + ROW_W + COL_W,
  parameter logic [AW-1:0] CTRL_BASE = '1,
  parameter logic [AW-1:0] CTRL_MASK = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cmd_e                      cmd,
  input  logic [BANK_W-1:0]         ba,
  input  logic [COL_W-1:0]          col,
  input  logic [NB-1:0][ROW_W-1:0]  rows,
  input  logic [NB-1:0]             emit_vec,
  input  logic [NB-1:0]             err_vec,
  output logic                      rec_valid,
  output logic [TS_W-1:0]           rec_ts,
  output logic                      rec_write,
  output logic [AW-1:0]             rec_addr,
  output logic                      rec_ctrl,
  output logic [ERR_W-1:0]          err_cnt
);

  logic [TS_W-1:0]  ts_q;
  logic             any_emit, any_err;
  logic [AW-1:0]    addr_d;
  logic             ctrl_d;
  logic             vld_q, wr_q, ctrl_q;
  logic [TS_W-1:0]  tsr_q;
  logic [AW-1:0]    addr_q;
  logic [ERR_W-1:0] err_q, err_d;
  logic             err_en;

  always_comb begin
    any_emit = |emit_vec;
    any_err  = |err_vec;
    addr_d   = {ba, rows[ba], col};
    ctrl_d   = ((addr_d & CTRL_MASK) == CTRL_BASE);
    err_en   = any_err && (err_q != {ERR_W{1'b1}});
    err_d    = err_q + {{(ERR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
    end else begin
      ts_q <= ts_q + {{(TS_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= any_emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      ctrl_q <= 1'b0;
    end else if (any_emit) begin
      tsr_q  <= ts_q;
      wr_q   <= (cmd == CMD_WR);
      addr_q <= addr_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign rec_valid = vld_q;
  assign rec_ts    = tsr_q;
  assign rec_write = wr_q;
  assign rec_addr  = addr_q;
  assign rec_ctrl  = ctrl_q;
  assign err_cnt   = err_q;

endmodule

// File: rtl/ddrtrk_top.sv
module ddrtrk_top
  import ddrtrk_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int TS_W   = 16,
  parameter int ERR_W  = 8,
  parameter logic [BANK_W+ROW_W+COL_W-1:0] CTRL_MASK =
    {{(BANK_W+ROW_W){1'b1}}, {COL_W{1'b0}}},
  parameter logic [BANK_W+ROW_W+COL_W-1:0] CTRL_BASE =
    {{(BANK_W+ROW_W){1'b1}}, {COL_W{1'b0}}}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BANK_W-1:0]             ba,
  input  logic [ROW_W-1:0]              addr,
  output logic                          rec_valid,
  output logic [TS_W-1:0]               rec_ts,
  output logic                          rec_write,
  output logic [BANK_W+ROW_W+COL_W-1:0] rec_addr,
  output logic                          rec_ctrl,
  output logic [ERR_W-1:0]              err_cnt
);

  localparam int NB = 1 << BANK_W;
  localparam int AW = BANK_W + ROW_W + COL_W;

  cmd_e                     cmd_q;
  logic [BANK_W-1:0]        ba_q;
  logic [ROW_W-1:0]         addr_q;
  logic [NB-1:0][ROW_W-1:0] bank_rows;
  logic [NB-1:0]            bank_emit;
  logic [NB-1:0]            bank_err;
  bank_st_e                 bank_st [NB];

  ddrtrk_cmd_decode #(.BANK_W(BANK_W), .ROW_W(ROW_W)) dec_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr   (addr),
    .cmd_o  (cmd_q),
    .ba_o   (ba_q),
    .addr_o (addr_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel_b;
    assign sel_b = (ba_q == BANK_W'(b));
    ddrtrk_bank_fsm #(.ROW_W(ROW_W)) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_b),
      .cmd     (cmd_q),
      .row_in  (addr_q),
      .state_o (bank_st[b]),
      .row_o   (bank_rows[b]),
      .emit_o  (bank_emit[b]),
      .err_o   (bank_err[b])
    );
  end

  ddrtrk_record #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TS_W(TS_W),
    .ERR_W(ERR_W), .NB(NB), .AW(AW),
    .CTRL_BASE(CTRL_BASE), .CTRL_MASK(CTRL_MASK)
  ) rec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_q),
    .ba        (ba_q),
    .col       (addr_q[COL_W-1:0]),
    .rows      (bank_rows),
    .emit_vec  (bank_emit),
    .err_vec   (bank_err),
    .rec_valid (rec_valid),
    .rec_ts    (rec_ts),
    .rec_write (rec_write),
    .rec_addr  (rec_addr),
    .rec_ctrl  (rec_ctrl),
    .err_cnt   (err_cnt)
  );

endmodule

// File: rtl/ddrtrk_checker.sv
module ddrtrk_checker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ERR_W  = 8,
  parameter int NB     = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cs_n,
  input logic                          ras_n,
  input logic                          cas_n,
  input logic                          we_n,
  input logic [BANK_W-1:0]             ba,
  input logic                          rec_valid,
  input logic                          rec_write,
  input logic [BANK_W+ROW_W+COL_W-1:0] rec_addr,
  input logic [ERR_W-1:0]              err_cnt,
  input logic [NB-1:0]                 bank_emit
);

  localparam int AW = BANK_W + ROW_W + COL_W;

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R3: a record only follows a sampled column command two edges earlier
  assert_rec_from_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && rec_valid) |->
      (!$past(cs_n, 2) && $past(ras_n, 2) && !$past(cas_n, 2)));

  // R4: write flag matches the pin pattern of that command
  assert_rec_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && rec_valid) |-> (rec_write == !$past(we_n, 2)));

  // R5: bank field of the record is the bank of that command
  assert_rec_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && rec_valid) |-> (rec_addr[AW-1 -: BANK_W] == $past(ba, 2)));

  // R2: at most one bank reacts to a command
  assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_emit));

  // R8: error count moves by at most one per cycle
  assert_err_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |->
      (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + ERR_W'(1)));

  // R8: an error step never comes with a record
  assert_err_no_rec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && err_cnt != $past(err_cnt)) |-> !rec_valid);

endmodule

bind ddrtrk_top ddrtrk_checker #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ERR_W(ERR_W), .NB(NB)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .rec_valid (rec_valid),
  .rec_write (rec_write),
  .rec_addr  (rec_addr),
  .err_cnt   (err_cnt),
  .bank_emit (bank_emit)
);

// File: tb/ddrtrk_top_tb_top.sv
module ddrtrk_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 10;
  localparam int TS_W   = 16;
  localparam int ERR_W  = 8;
  localparam int NB     = 1 << BANK_W;
  localparam int AW     = BANK_W + ROW_W + COL_W;

  typedef struct {
    logic [TS_W-1:0] ts;
    logic            wr;
    logic [AW-1:0]   addr;
    logic            ctrl;
    string           tag;
  } exp_t;

  logic clk, rst_n, cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0]  addr;
  logic              rec_valid, rec_write, rec_ctrl;
  logic [TS_W-1:0]   rec_ts;
  logic [AW-1:0]     rec_addr;
  logic [ERR_W-1:0]  err_cnt;

  int unsigned tb_cyc;
  int n_checks, n_fail;
  bit finished;
  exp_t exp_q[$];
  logic [ROW_W-1:0] m_row [NB];
  bit               m_open [NB];
  int               m_err;

  ddrtrk_top #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
               .TS_W(TS_W), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .rec_valid(rec_valid),
    .rec_ts(rec_ts), .rec_write(rec_write), .rec_addr(rec_addr),
    .rec_ctrl(rec_ctrl), .err_cnt(err_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cyc <= 0;
    else        tb_cyc <= tb_cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Monitor: compare each record against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected record", {7'b0, rec_addr}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rec_addr == e.addr, {e.tag, " address"}, {7'b0, rec_addr}, {7'b0, e.addr});
        check(rec_write == e.wr, {e.tag, " R4 direction"}, {31'b0, rec_write}, {31'b0, e.wr});
        check(rec_ts == e.ts, {e.tag, " R9 timestamp"}, {16'b0, rec_ts}, {16'b0, e.ts});
        check(rec_ctrl == e.ctrl, {e.tag, " R10 window"}, {31'b0, rec_ctrl}, {31'b0, e.ctrl});
      end
    end
  end

  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic act(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] row);
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, row);
    m_row[b] = row;
    m_open[b] = 1;
  endtask

  task automatic col(input bit wr, input logic [BANK_W-1:0] b,
                     input logic [COL_W-1:0] c, input string tag);
    drive(1'b0, 1'b1, 1'b0, !wr, b, ROW_W'(c));
    if (m_open[b]) begin
      exp_t e;
      e.ts   = TS_W'(tb_cyc);
      e.wr   = wr;
      e.addr = {b, m_row[b], c};
      e.ctrl = (b == '1) && (m_row[b] == '1);
      e.tag  = tag;
      exp_q.push_back(e);
    end else if (m_err < (1 << ERR_W) - 1) begin
      m_err++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; finished = 0; m_err = 0;
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = '0; end
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = '0; addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(rec_valid == 1'b0, "R1 valid in reset", {31'b0, rec_valid}, 32'h0);
    check(err_cnt == '0, "R1 errors in reset", {24'b0, err_cnt}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check(rec_valid == 1'b0, "R1 valid after reset", {31'b0, rec_valid}, 32'h0);

    // R8: column commands to idle banks
    col(0, 2'd0, 10'h005, "R8");
    col(1, 2'd1, 10'h006, "R8");
    nop(2);
    check(err_cnt == ERR_W'(m_err), "R8 idle bank errors", {24'b0, err_cnt}, m_err);

    // R3 / R4 / R6: one bank, read then writes and repeats
    act(2'd0, 13'h0123);
    col(0, 2'd0, 10'h03A, "R3");
    col(1, 2'd0, 10'h010, "R4");
    col(0, 2'd0, 10'h011, "R6");
    col(0, 2'd0, 10'h012, "R6");
    nop(3);

    // R5: interleaved banks
    act(2'd1, 13'h00AA);
    col(0, 2'd0, 10'h001, "R5");
    col(1, 2'd1, 10'h002, "R5");
    col(0, 2'd0, 10'h003, "R5");
    col(1, 2'd1, 10'h3FF, "R5");
    nop(3);

    // R2: ignored patterns, deselected ACTIVE, then probe the rows
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 13'h0777);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 13'h0666);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 13'h0555);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 13'h0444);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 13'h0001);
    nop(2);
    check(err_cnt == ERR_W'(m_err), "R2 no error from ignored", {24'b0, err_cnt}, m_err);
    col(0, 2'd0, 10'h004, "R2");
    col(0, 2'd1, 10'h005, "R2");
    nop(3);

    // R7: reopen with a new row
    act(2'd0, 13'h0456);
    col(0, 2'd0, 10'h007, "R7");
    col(1, 2'd1, 10'h008, "R7");
    nop(3);

    // R10: control window inside and just outside
    act(2'd3, 13'h1FFF);
    col(0, 2'd3, 10'h040, "R10");
    act(2'd3, 13'h1FFE);
    col(1, 2'd3, 10'h000, "R10");
    act(2'd2 & 2'd1, 13'h1FFF);
    col(0, 2'd0, 10'h040, "R10");
    nop(3);

    // R8: saturation on bank 2, which stays idle
    for (int i = 0; i < 260; i++) col(0, 2'd2, COL_W'(i), "R8");
    nop(3);
    check(err_cnt == {ERR_W{1'b1}}, "R8 saturation", {24'b0, err_cnt}, {24'b0, {ERR_W{1'b1}}});
    check(m_err == (1 << ERR_W) - 1, "R8 model saturation", m_err, (1 << ERR_W) - 1);

    nop(4);
    check(exp_q.size() == 0, "R3 all records seen", exp_q.size(), 32'h0);
    finish_run();
  end

endmodule